// File: doc/BRIEF.md
# Phase-Aligned Analog Register Write Synchronizer

This block sits on the path from a CPU IO write port to a bank of switched-capacitor configuration registers. All of its logic runs on the 24 MHz master clock. It also takes the two phases of the analog column clock, `phi1_in` and `phi2_in`, as plain inputs and samples them on that clock. A write can reach the block on any master-clock edge, in either phase. If a configuration register changes while the analog circuit is settling, the analog output can glitch. This block moves such writes to the start of the PHI1 phase.

When `sync_en` is low, every write goes straight through in the cycle it arrives. When `sync_en` is high, a write that targets the switched-capacitor address window is held instead, and `cpu_stall` is raised in the cycle the strobe appears. The held address and data are stored in a single holding slot. The write is then issued as a one-cycle `reg_wr` pulse on the next rising edge of PHI1, and `cpu_stall` drops in that same cycle. Writes outside the window are never held, whatever the value of `sync_en`. As an alternative to stalling, software can use `col_irq`. This output pulses for one cycle when PHI2 falls, which is the moment PHI1 begins.

The control logic is a two-state machine. `ST_IDLE` passes writes through. On a deferred write it takes the *defer* transition to `ST_HOLD`. `ST_HOLD` keeps the CPU stalled and ignores the bus. On a PHI1 rising edge it takes the *release* transition back to `ST_IDLE`. Every other condition keeps the current state.

Top module: `aw_phase_sync`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `cpu_stall`, `reg_wr` and `col_irq` are all 0.
- R2: With `sync_en`=0, a write strobe (`cpu_wr`=1) in idle gives `reg_wr`=1 in the same cycle, with `reg_addr`/`reg_wdata` equal to `cpu_addr`/`cpu_wdata`, and `cpu_stall`=0.
- R3: A write whose address is outside the window SC_LO..SC_HI (default 0x80..0x9F, both ends included) always passes through in the same cycle with `cpu_stall`=0, even when `sync_en`=1.
- R4: With `sync_en`=1, a write in idle to an address inside the window gives `cpu_stall`=1 and `reg_wr`=0 in the cycle of the strobe.
- R5: A held write is released in the first cycle in which `phi1_in` is sampled 1 after being 0 in the previous cycle. In that cycle `reg_wr`=1 for exactly one cycle, with the held address and data, and `cpu_stall`=0 in the same cycle.
- R6: A deferred write whose strobe coincides with a PHI1 rising edge is not released on that edge. It waits for the next PHI1 rising edge.
- R7: While a write is held, including the release cycle, further `cpu_wr` strobes are ignored. They produce no extra `reg_wr` and do not change the held address or data.
- R8: `col_irq` is 1 for exactly the one cycle in which `phi2_in` is sampled 0 after being 1 in the previous cycle, independent of `sync_en`.
- R9: A held write keeps `cpu_stall`=1 through any number of cycles of either phase until a PHI1 rising edge, whether it arrived during PHI1 or PHI2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en | input | 1 | 1 = hold window writes until PHI1 rises |
| phi1_in | input | 1 | Column clock phase 1 level |
| phi2_in | input | 1 | Column clock phase 2 level |
| cpu_wr | input | 1 | CPU IO write strobe |
| cpu_addr | input | AW | CPU write address |
| cpu_wdata | input | DW | CPU write data |
| cpu_stall | output | 1 | Stall request to the CPU |
| reg_wr | output | 1 | Write strobe to the register bank |
| reg_addr | output | AW | Register bank write address |
| reg_wdata | output | DW | Register bank write data |
| col_irq | output | 1 | One-cycle pulse on PHI2 falling edge |

## Verification
Writes are applied with synchronization off, with it on for addresses just outside and at both ends of the window, and with it on for writes that arrive during PHI2, during PHI1, and exactly on a PHI1 rising edge. These cases show whether the defer decision looks at both the enable bit and the address, and whether the release picks the correct edge. A held write is also hit with further strobes, including one in the release cycle. This shows whether the holding slot can be overwritten and whether extra writes can leak through. The interrupt pulse is checked with synchronization both on and off, to confirm that it follows only the PHI2 falling edge.

// File: rtl/aws_pkg.sv
package aws_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } aws_state_e;
endpackage

// File: rtl/aws_edge_det.sv
module aws_edge_det #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic pulse
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = sig & ~sig_q;
        end else begin : g_fall
            assign pulse = ~sig & sig_q;
        end
    endgenerate
endmodule

// File: rtl/aws_range_dec.sv
module aws_range_dec #(
    parameter int          AW = 8,
    parameter logic [AW-1:0] LO = 'h80,
    parameter logic [AW-1:0] HI = 'h9F
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    assign hit = (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/aws_hold_reg.sv
module aws_hold_reg #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (load) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end
endmodule

// File: rtl/aw_phase_sync.sv
module aw_phase_sync
    import aws_pkg::*;
#(
    parameter int            AW    = 8,
    parameter int            DW    = 8,
    parameter logic [AW-1:0] SC_LO = 'h80,
    parameter logic [AW-1:0] SC_HI = 'h9F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_en,
    input  logic          phi1_in,
    input  logic          phi2_in,
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_stall,
    output logic          reg_wr,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          col_irq
);
    aws_state_e    state_q, state_d;
    logic          phi1_rise;
    logic          sc_hit;
    logic          defer;
    logic          load;
    logic [AW-1:0] held_addr;
    logic [DW-1:0] held_data;
    logic          pending;

    aws_edge_det #(.RISING(1'b1)) u_phi1_edge (
        .clk(clk), .rst_n(rst_n), .sig(phi1_in), .pulse(phi1_rise)
    );

    aws_edge_det #(.RISING(1'b0)) u_phi2_edge (
        .clk(clk), .rst_n(rst_n), .sig(phi2_in), .pulse(col_irq)
    );

    aws_range_dec #(.AW(AW), .LO(SC_LO), .HI(SC_HI)) u_dec (
        .addr(cpu_addr), .hit(sc_hit)
    );

    aws_hold_reg #(.AW(AW), .DW(DW)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(load),
        .addr_in(cpu_addr), .data_in(cpu_wdata),
        .addr_q(held_addr), .data_q(held_data)
    );

    assign defer   = sync_en & sc_hit;
    assign pending = (state_q == ST_HOLD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cpu_wr && defer) state_d = ST_HOLD;
            ST_HOLD: if (phi1_rise)       state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_stall = 1'b0;
        reg_wr    = 1'b0;
        load      = 1'b0;
        reg_addr  = cpu_addr;
        reg_wdata = cpu_wdata;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_wr) begin
                    if (defer) begin
                        cpu_stall = 1'b1;
                        load      = 1'b1;
                    end else begin
                        reg_wr = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                reg_addr  = held_addr;
                reg_wdata = held_data;
                if (phi1_rise) reg_wr    = 1'b1;
                else           cpu_stall = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/aw_phase_sync_chk.sv
module aw_phase_sync_chk #(
    parameter int            AW    = 8,
    parameter int            DW    = 8,
    parameter logic [AW-1:0] SC_LO = 'h80,
    parameter logic [AW-1:0] SC_HI = 'h9F
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync_en,
    input logic          phi1_in,
    input logic          cpu_wr,
    input logic [AW-1:0] cpu_addr,
    input logic [DW-1:0] cpu_wdata,
    input logic          cpu_stall,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          pending
);
    logic in_win;
    assign in_win = (cpu_addr >= SC_LO) && (cpu_addr <= SC_HI);

    p_no_wr_while_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && cpu_stall));

    p_passthrough_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !pending && !sync_en) |->
            (reg_wr && !cpu_stall && reg_addr == cpu_addr && reg_wdata == cpu_wdata));

    p_out_of_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !pending && !in_win) |-> (reg_wr && !cpu_stall));

    p_stall_on_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !pending && sync_en && in_win) |-> (cpu_stall && !reg_wr));

    p_release_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && phi1_in && !$past(phi1_in)) |-> (reg_wr && !cpu_stall));

    p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && pending) |=> !pending);

    p_no_same_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !pending && sync_en && in_win) |=> pending);

    p_hold_stalls_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !(phi1_in && !$past(phi1_in))) |-> (cpu_stall && !reg_wr));
endmodule

bind aw_phase_sync aw_phase_sync_chk #(
    .AW(AW), .DW(DW), .SC_LO(SC_LO), .SC_HI(SC_HI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .phi1_in(phi1_in),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_stall(cpu_stall), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pending(pending)
);

// File: tb/aw_phase_sync_tb_top.sv
`timescale 1ns/1ps
module aw_phase_sync_tb_top;
    localparam int AW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sync_en;
    logic          phi1_in;
    logic          phi2_in;
    logic          cpu_wr;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata;
    logic          cpu_stall;
    logic          reg_wr;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic          col_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    aw_phase_sync #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en),
        .phi1_in(phi1_in), .phi2_in(phi2_in),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_stall(cpu_stall), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .col_irq(col_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_idle_out(input string req);
        check({req, " stall"}, cpu_stall, 0);
        check({req, " reg_wr"}, reg_wr, 0);
    endtask

    task automatic expect_release(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d);
        check({req, " reg_wr"}, reg_wr, 1);
        check({req, " stall"}, cpu_stall, 0);
        check({req, " addr"}, reg_addr, a);
        check({req, " data"}, reg_wdata, d);
    endtask

    task automatic expect_held(input string req);
        check({req, " stall"}, cpu_stall, 1);
        check({req, " reg_wr"}, reg_wr, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; sync_en = 1'b0; phi1_in = 1'b0; phi2_in = 1'b0;
        cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(negedge clk);
        #1;
        expect_idle_out("R1 in reset");
        check("R1 irq in reset", col_irq, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        expect_idle_out("R1 after reset");
        check("R1 irq after reset", col_irq, 0);
    endtask

    task automatic t_sync_off;
        @(negedge clk);
        sync_en = 1'b0; cpu_wr = 1'b1; cpu_addr = 8'h85; cpu_wdata = 8'h3C;
        #1;
        expect_release("R2 passthrough", 8'h85, 8'h3C);
        @(negedge clk);
        cpu_wr = 1'b0;
        #1;
        expect_idle_out("R2 after");
    endtask

    task automatic t_out_of_window;
        logic [AW-1:0] addrs [4] = '{8'h7F, 8'hA0, 8'h00, 8'hFF};
        sync_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cpu_wr = 1'b1; cpu_addr = addrs[i]; cpu_wdata = 8'h40 + 8'(i);
            #1;
            expect_release("R3 outside window", addrs[i], 8'h40 + 8'(i));
        end
        @(negedge clk);
        cpu_wr = 1'b0;
        #1;
        expect_idle_out("R3 after");
    endtask

    task automatic t_arrive_phi2;
        @(negedge clk);
        phi2_in = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 8'h80; cpu_wdata = 8'h11;
        #1;
        expect_held("R4 low edge of window");
        @(negedge clk);
        cpu_wr = 1'b0;
        for (int i = 0; i < 3; i++) begin
            #1;
            expect_held("R9 phi2 wait");
            @(negedge clk);
        end
        phi2_in = 1'b0; phi1_in = 1'b1;
        #1;
        check("R8 irq on phi2 fall", col_irq, 1);
        expect_release("R5 release", 8'h80, 8'h11);
        @(negedge clk);
        #1;
        expect_idle_out("R5 single strobe");
        check("R8 irq one cycle", col_irq, 0);
    endtask

    task automatic t_arrive_phi1;
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 8'h9F; cpu_wdata = 8'hA5;
        #1;
        expect_held("R4 high edge of window");
        @(negedge clk);
        cpu_wr = 1'b0;
        #1;
        expect_held("R9 phi1 high wait");
        @(negedge clk);
        phi1_in = 1'b0;
        #1;
        expect_held("R9 gap wait");
        @(negedge clk);
        phi2_in = 1'b1;
        #1;
        expect_held("R9 phi2 wait");
        @(negedge clk);
        phi2_in = 1'b0; phi1_in = 1'b1;
        #1;
        expect_release("R5 release after phi1 arrival", 8'h9F, 8'hA5);
        @(negedge clk);
        phi1_in = 1'b0;
        #1;
        expect_idle_out("R5 after");
    endtask

    task automatic t_coincide;
        @(negedge clk);
        phi1_in = 1'b1; cpu_wr = 1'b1; cpu_addr = 8'h90; cpu_wdata = 8'h5A;
        #1;
        expect_held("R6 arrival on rise");
        @(negedge clk);
        cpu_wr = 1'b0;
        #1;
        expect_held("R6 not released on own edge");
        @(negedge clk);
        phi1_in = 1'b0;
        #1;
        expect_held("R6 waiting");
        @(negedge clk);
        phi1_in = 1'b1;
        #1;
        expect_release("R6 next rise", 8'h90, 8'h5A);
        @(negedge clk);
        phi1_in = 1'b0;
        #1;
        expect_idle_out("R6 after");
    endtask

    task automatic t_ignore_while_held;
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 8'h88; cpu_wdata = 8'h77;
        #1;
        expect_held("R4 entry");
        @(negedge clk);
        cpu_addr = 8'h10; cpu_wdata = 8'hFF;
        #1;
        expect_held("R7 outside-window strobe ignored");
        @(negedge clk);
        cpu_addr = 8'h89; cpu_wdata = 8'hEE;
        #1;
        expect_held("R7 in-window strobe ignored");
        @(negedge clk);
        phi1_in = 1'b1; cpu_addr = 8'h10; cpu_wdata = 8'hFF;
        #1;
        expect_release("R7 held values kept", 8'h88, 8'h77);
        @(negedge clk);
        cpu_wr = 1'b0; phi1_in = 1'b0;
        #1;
        expect_idle_out("R7 no extra strobe");
    endtask

    task automatic t_irq_sync_off;
        @(negedge clk);
        sync_en = 1'b0; phi2_in = 1'b1;
        #1;
        check("R8 no irq while high", col_irq, 0);
        @(negedge clk);
        phi2_in = 1'b0;
        #1;
        check("R8 irq with sync off", col_irq, 1);
        @(negedge clk);
        #1;
        check("R8 irq ends", col_irq, 0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL R5 watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_sync_off();
        t_out_of_window();
        t_arrive_phi2();
        t_arrive_phi1();
        t_coincide();
        t_ignore_while_held();
        t_irq_sync_off();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule